// File: doc/BRIEF.md
# Power-Up Strap Capture and Frequency Index Selector

This block sits between the multiplexed configuration pins of a clock generator and its synthesis fabric. At power-up six pins that later carry clocks are read as configuration straps: three frequency-select bits, a pin-role mode bit, a CPU output supply bit and an SDRAM clock source bit. The block holds those values for the rest of the run. It keeps the pin output drivers off until a short turnaround has passed, and then hands the pins over to their clock role.

After capture, the block merges the three-bit hardware code with a four-bit software code. A register bit chooses which of the two is used, and the result is a four-bit frequency index. The latched mode bit sets the role of two more shared pins. They are either SDRAM clock outputs, or active-low stop inputs for the CPU and PCI clock groups. Stop requests pass through a synchronizer. The matching run enable changes only while that clock sits low, so stopping or restarting a clock never produces a runt pulse.

A controller FSM has three states:
- `ST_POR`: power-on reset is held, and nothing is driven.
- `ST_TURN`: the straps are captured, and the drivers are still off.
- `ST_RUN`: the pins are driven.

The FSM moves through three transitions:
- capture: `ST_POR`→`ST_TURN`, on the first clock after reset release.
- turn-done: `ST_TURN`→`ST_RUN`, after `TURN_CYC` clocks.
- power-on reset: any state→`ST_POR`, asynchronously.

Top module: `clk_strap_select`

## Requirements
- R1: While `por_n` is low, `strap_pin_oe` and `share_pin_oe` are all zero, `cpu_run` and `pci_run` are 1, and the strap values read as the pull-up default of all ones. In that state `freq_idx` is 4'b0111, `cpu_low_volt` is 1 and `sdram_from_cpu` is 1.
- R2: The straps are captured at the first rising clock after `por_n` goes high. Later changes on the strap pins have no effect on any output.
- R3: `strap_pin_oe` stays 6'b000000 until `TURN_CYC` (default 2) further rising clocks after the capture clock, and is 6'b111111 afterwards. Its bit order is [0] 48 MHz/FS0, [1] free-running PCI/FS1, [2] PCI0/FS2, [3] 24 MHz/mode, [4] REF0/supply, [5] REF1/SDRAM source.
- R4: With `sw_override` at 0, `freq_idx` equals {1'b0, FS2, FS1, FS0}, where `pad_fs[0]` is FS0.
- R5: With `sw_override` at 1, `freq_idx` equals `sw_code`. All 16 values are reachable, and the output follows at once, without a clock.
- R6: `cpu_low_volt` equals the latched REF0 strap (1 means 2.5 V outputs, 0 means 3.3 V). `sdram_from_cpu` equals the latched REF1 strap (1 means the CPU frequency, 0 means the AGP frequency).
- R7: If the latched mode bit is 1, `share_pin_oe` becomes 2'b11 together with `strap_pin_oe`, and both stop pins are ignored. If the mode bit is 0, `share_pin_oe` stays 2'b00.
- R8: In mode 0 during `ST_RUN`, a low level on `pad_cpu_stop_n` clears `cpu_run` and a low level on `pad_pci_stop_n` clears `pci_run`. The two are independent. With the clock level held low, each change appears `SYNC_STAGES`+1 (default 3) rising clocks after the pin changes.
- R9: `cpu_run` (and `pci_run`) changes only at a rising clock where `cpu_clk_lvl` (`pci_clk_lvl`) is 0. A request made while the level is high waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pad_fs | input | 3 | Levels on the FS0/FS1/FS2 strap pins |
| pad_mode | input | 1 | Level on the mode strap pin |
| pad_cpu_lv | input | 1 | Level on the CPU supply strap pin |
| pad_sd_cpu | input | 1 | Level on the SDRAM source strap pin |
| sw_override | input | 1 | 1 selects the software code |
| sw_code | input | 4 | Software frequency code |
| pad_cpu_stop_n | input | 1 | Shared pin level, CPU stop (mode 0) |
| pad_pci_stop_n | input | 1 | Shared pin level, PCI stop (mode 0) |
| cpu_clk_lvl | input | 1 | Current level of the CPU clock group |
| pci_clk_lvl | input | 1 | Current level of the gated PCI clocks |
| freq_idx | output | 4 | Active frequency index |
| sdram_from_cpu | output | 1 | SDRAM clocks follow CPU (1) or AGP (0) |
| cpu_low_volt | output | 1 | CPU outputs on the 2.5 V supply |
| strap_pin_oe | output | 6 | Driver enables of the strap pins |
| share_pin_oe | output | 2 | Driver enables of the two mode-shared pins |
| cpu_run | output | 1 | CPU clock group enable |
| pci_run | output | 1 | Gated PCI clock enable |

## Verification
The bench changes the strap pins right after the capture clock. A design that samples continuously would then show a new frequency index. It checks the driver enables one clock before and at the end of the turnaround; an off-by-one counter would turn the drivers on early, while a strap is still being read. It raises a stop request while the clock level is high and confirms that the enable waits; a design without this guard would cut a clock mid-pulse. A second power-up in mode 1 with the stop pins held low shows whether the stops are wrongly honoured while the pins are SDRAM outputs.

// File: rtl/strapsel_pkg.sv
package strapsel_pkg;

    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_TURN = 2'd1,
        ST_RUN  = 2'd2
    } strap_state_e;

    typedef struct packed {
        logic [2:0] fs;
        logic       mode;
        logic       cpu_lv;
        logic       sd_cpu;
    } strap_set_t;

    localparam int N_STRAP_PINS = 6;
    localparam int N_SHARE_PINS = 2;

    localparam strap_set_t STRAP_PULLUP = '{fs: 3'b111, mode: 1'b1, cpu_lv: 1'b1, sd_cpu: 1'b1};

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stop_gate.sv
module stop_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_lvl,
    input  logic stop_req,
    output logic run
);
    logic run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= 1'b1;
        else if (!clk_lvl) run_q <= !stop_req;
    end

    assign run = run_q;

    // R9
    run_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_q) |-> !$past(clk_lvl));
endmodule

// File: rtl/strap_fsm.sv
module strap_fsm
    import strapsel_pkg::*;
#(
    parameter int TURN_CYC = 2
) (
    input  logic         clk,
    input  logic         por_n,
    input  strap_set_t   pad_straps,
    output strap_set_t   straps,
    output strap_state_e state,
    output logic         drivers_on
);
    localparam int CW = $clog2(TURN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TURN_CYC - 1);

    strap_state_e st, st_nx;
    logic [CW-1:0] cnt;
    strap_set_t    strap_q;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_POR:  st_nx = ST_TURN;
            ST_TURN: if (cnt == LAST) st_nx = ST_RUN;
            ST_RUN:  st_nx = ST_RUN;
            default: st_nx = ST_POR;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st <= ST_POR;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt     <= '0;
            strap_q <= STRAP_PULLUP;
        end else begin
            unique case (st)
                ST_POR: begin
                    strap_q <= pad_straps;
                    cnt     <= '0;
                end
                ST_TURN: cnt <= cnt + 1'b1;
                ST_RUN:  cnt <= cnt;
                default: cnt <= '0;
            endcase
        end
    end

    assign straps     = strap_q;
    assign state      = st;
    assign drivers_on = (st == ST_RUN);

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st != ST_POR && $past(st) != ST_POR) |-> $stable(strap_q));

    // R3
    turn_cnt_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st == ST_TURN) |-> (cnt < CW'(TURN_CYC)));
endmodule

// File: rtl/clk_strap_select.sv
module clk_strap_select
    import strapsel_pkg::*;
#(
    parameter int TURN_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic [2:0] pad_fs,
    input  logic       pad_mode,
    input  logic       pad_cpu_lv,
    input  logic       pad_sd_cpu,
    input  logic       sw_override,
    input  logic [3:0] sw_code,
    input  logic       pad_cpu_stop_n,
    input  logic       pad_pci_stop_n,
    input  logic       cpu_clk_lvl,
    input  logic       pci_clk_lvl,
    output logic [3:0] freq_idx,
    output logic       sdram_from_cpu,
    output logic       cpu_low_volt,
    output logic [5:0] strap_pin_oe,
    output logic [1:0] share_pin_oe,
    output logic       cpu_run,
    output logic       pci_run
);
    strap_set_t   pad_straps;
    strap_set_t   straps;
    strap_state_e state;
    logic         drivers_on;

    assign pad_straps = '{fs: pad_fs, mode: pad_mode, cpu_lv: pad_cpu_lv, sd_cpu: pad_sd_cpu};

    strap_fsm #(.TURN_CYC(TURN_CYC)) u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .pad_straps (pad_straps),
        .straps     (straps),
        .state      (state),
        .drivers_on (drivers_on)
    );

    // Frequency index merge
    always_comb begin
        if (sw_override) freq_idx = sw_code;
        else             freq_idx = {1'b0, straps.fs};
    end

    assign sdram_from_cpu = straps.sd_cpu;
    assign cpu_low_volt   = straps.cpu_lv;
    assign strap_pin_oe   = {N_STRAP_PINS{drivers_on}};
    assign share_pin_oe   = {N_SHARE_PINS{drivers_on & straps.mode}};

    // Stop channels: index 0 = PCI, 1 = CPU
    logic [1:0] stop_pin_n;
    logic [1:0] lvl;
    logic [1:0] stop_sync;
    logic [1:0] run_vec;
    logic       stops_live;

    assign stop_pin_n = {pad_cpu_stop_n, pad_pci_stop_n};
    assign lvl        = {cpu_clk_lvl, pci_clk_lvl};
    assign stops_live = drivers_on & ~straps.mode;

    generate
        for (genvar c = 0; c < 2; c++) begin : g_chan
            strap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
                .clk   (clk),
                .rst_n (por_n),
                .d     (~stop_pin_n[c]),
                .q     (stop_sync[c])
            );
            stop_gate u_gate (
                .clk      (clk),
                .rst_n    (por_n),
                .clk_lvl  (lvl[c]),
                .stop_req (stop_sync[c] & stops_live),
                .run      (run_vec[c])
            );
        end
    endgenerate

    assign pci_run = run_vec[0];
    assign cpu_run = run_vec[1];

    // R7
    mode1_run_chk: assert property (@(posedge clk) disable iff (!por_n)
        (drivers_on && straps.mode) |-> (&run_vec));
endmodule

// File: tb/test_clk_strap_select.sv
module test_clk_strap_select;
    logic       clk = 1'b0;
    logic       por_n;
    logic [2:0] pad_fs;
    logic       pad_mode, pad_cpu_lv, pad_sd_cpu;
    logic       sw_override;
    logic [3:0] sw_code;
    logic       pad_cpu_stop_n, pad_pci_stop_n;
    logic       cpu_clk_lvl, pci_clk_lvl;
    logic [3:0] freq_idx;
    logic       sdram_from_cpu, cpu_low_volt;
    logic [5:0] strap_pin_oe;
    logic [1:0] share_pin_oe;
    logic       cpu_run, pci_run;

    int total = 0;
    int bad = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    clk_strap_select i_clk_strap_select (
        .clk(clk), .por_n(por_n), .pad_fs(pad_fs), .pad_mode(pad_mode),
        .pad_cpu_lv(pad_cpu_lv), .pad_sd_cpu(pad_sd_cpu),
        .sw_override(sw_override), .sw_code(sw_code),
        .pad_cpu_stop_n(pad_cpu_stop_n), .pad_pci_stop_n(pad_pci_stop_n),
        .cpu_clk_lvl(cpu_clk_lvl), .pci_clk_lvl(pci_clk_lvl),
        .freq_idx(freq_idx), .sdram_from_cpu(sdram_from_cpu),
        .cpu_low_volt(cpu_low_volt), .strap_pin_oe(strap_pin_oe),
        .share_pin_oe(share_pin_oe), .cpu_run(cpu_run), .pci_run(pci_run)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Driver for the index scoreboard
    task automatic sw_drive(logic ov, logic [3:0] code, logic [3:0] exp, string tag);
        step(1);
        sw_override = ov;
        sw_code     = code;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {4'h0, freq_idx}, {4'h0, e});
        end
    end

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        por_n = 1'b0; pad_fs = 3'b101; pad_mode = 1'b0; pad_cpu_lv = 1'b1; pad_sd_cpu = 1'b0;
        sw_override = 1'b0; sw_code = 4'h0;
        pad_cpu_stop_n = 1'b1; pad_pci_stop_n = 1'b1; cpu_clk_lvl = 1'b0; pci_clk_lvl = 1'b0;
        step(3);
        // R1 reset state
        check("R1 oe", {share_pin_oe, strap_pin_oe}, 8'h00);
        check("R1 idx", {4'h0, freq_idx}, 8'h07);
        check("R1 misc", {4'h0, cpu_low_volt, sdram_from_cpu, cpu_run, pci_run}, 8'h0F);
        por_n = 1'b1;
        step(1);
        // R2, R4, R6 captured values
        check("R4 hw idx", {4'h0, freq_idx}, 8'h05);
        check("R6 supply/sdram", {6'h0, cpu_low_volt, sdram_from_cpu}, 8'h02);
        check("R3 oe off at capture", {2'b0, strap_pin_oe}, 8'h00);
        pad_fs = 3'b010; pad_cpu_lv = 1'b0; pad_sd_cpu = 1'b1; pad_mode = 1'b1;
        step(1);
        check("R2 pads ignored", {freq_idx, 2'b0, cpu_low_volt, sdram_from_cpu}, {4'h5, 4'h2});
        check("R3 oe off before end", {2'b0, strap_pin_oe}, 8'h00);
        step(1);
        check("R3 oe on", {2'b0, strap_pin_oe}, 8'h3F);
        check("R7 mode0 share off", {6'h0, share_pin_oe}, 8'h00);
        // R5 via scoreboard
        sw_drive(1'b1, 4'hF, 4'hF, "R5 code F");
        sw_drive(1'b1, 4'h8, 4'h8, "R5 code 8");
        sw_drive(1'b1, 4'h0, 4'h0, "R5 code 0");
        sw_drive(1'b0, 4'hA, 4'h5, "R4 back to hw");
        step(2);
        // R9: stop while level high waits
        cpu_clk_lvl = 1'b1;
        pad_cpu_stop_n = 1'b0;
        step(4);
        check("R9 wait while high", {7'h0, cpu_run}, 8'h01);
        cpu_clk_lvl = 1'b0;
        step(1);
        check("R8 cpu stopped", {6'h0, cpu_run, pci_run}, 8'h01);
        pad_cpu_stop_n = 1'b1;
        step(2);
        check("R8 restart latency", {7'h0, cpu_run}, 8'h00);
        step(1);
        check("R8 cpu restarted", {7'h0, cpu_run}, 8'h01);
        pad_pci_stop_n = 1'b0;
        step(2);
        check("R8 pci not yet", {7'h0, pci_run}, 8'h01);
        step(1);
        check("R8 pci stopped", {6'h0, cpu_run, pci_run}, 8'h02);
        pad_pci_stop_n = 1'b1;
        step(3);
        check("R8 pci restarted", {7'h0, pci_run}, 8'h01);
        // Second power-up, pull-up defaults, mode 1
        por_n = 1'b0;
        pad_fs = 3'b111; pad_mode = 1'b1; pad_cpu_lv = 1'b1; pad_sd_cpu = 1'b1;
        step(2);
        check("R1 second reset oe", {share_pin_oe, strap_pin_oe}, 8'h00);
        por_n = 1'b1;
        step(3);
        check("R7 mode1 share on", {share_pin_oe, strap_pin_oe}, 8'hFF);
        check("R6 pull-up straps", {freq_idx, 2'b0, cpu_low_volt, sdram_from_cpu}, 8'h73);
        pad_cpu_stop_n = 1'b0; pad_pci_stop_n = 1'b0;
        step(6);
        check("R7 stops ignored", {6'h0, cpu_run, pci_run}, 8'h03);
        step(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule